// File: doc/BRIEF.md
# Serial Port Register Front End with Delayed Interrupts

This block is the byte-wide, memory-mapped register face of a simple serial port. A host reaches eight byte offsets through a single-cycle access strobe. The block holds the interrupt-enable, line-control and modem-control registers, and builds the line status and interrupt identification values from its internal state. Bytes the host writes to the data offset leave on a one-cycle transmit strobe. Bytes the host reads from the data offset are popped from a receive source that shows a data-available flag.

Transmit-empty interrupts, and receive interrupts for data still waiting after a read, are not raised at once. A per-direction delay timer of `DELAY_CYCLES` clocks runs first, and the interrupt is raised only if its enable bit is still set when the timer runs out. Fresh receive data, seen as a rising data-available flag, raises the receive interrupt on the next clock. A single level-sensitive interrupt line goes to the host. Divisor accesses, baud generation, serial shifting, FIFOs and modem lines are outside the block.

Top module: `serial_csr_front`

## Requirements
- R1: Offset 3 (line control) reads back the last byte written to it, offset 1 (interrupt enable) does the same while line-control bit 7 is clear, and offsets 6 and 7 always read 0x00. After reset, interrupt enable, line control and modem control read 0x00 and the interrupt output is low.
- R2: While line-control bit 7 is set, offsets 0 and 1 read 0x00, writes to them change nothing (no transmit strobe, interrupt enable unchanged), and a read of offset 0 pops no byte.
- R3: A read of offset 0 with bit 7 clear returns the head receive byte and pops it when data is available, returns 0x00 otherwise, and clears receive-pending.
- R4: A write of offset 0 with bit 7 clear drives the byte out with a one-cycle transmit strobe in the same cycle, clears transmit-pending and, if interrupt-enable bit 1 is set, restarts the transmit delay.
- R5: Offset 2 reads 0x04 while receive-pending is set, otherwise 0x02 while transmit-pending is set, otherwise 0x01.
- R6: Reading offset 2 clears transmit-pending and leaves receive-pending unchanged.
- R7: Offset 5 reads 0x60 with no receive data available and 0x61 with data available (bit 0 data ready; bits 5 and 6 always 1).
- R8: Writing interrupt enable with bit 1 set (re)starts the transmit delay; with bit 1 clear it cancels that delay and clears transmit-pending. Bit 0 does the same for the receive side, except that the receive delay starts only when data is available.
- R9: A delay started at clock edge E sets its pending bit at edge E + DELAY_CYCLES (default 450) and not before; a restart reloads the full interval, and on expiry the pending bit is set only if its enable bit is still set.
- R10: Writing 0x1A to offset 4 makes it read 0x9A; any other written value leaves offset 4 unchanged.
- R11: A rising data-available flag with interrupt-enable bit 0 set sets receive-pending at the next edge. After a data read, if data is still available at the following edge, the receive delay starts at that edge.
- R12: The interrupt output is high exactly when receive-pending or transmit-pending is set; writes to offsets 2 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| tx_valid | output | 1 | Transmit strobe, one cycle per byte |
| tx_byte | output | 8 | Byte to transmit |
| rx_avail | input | 1 | Receive source holds at least one byte |
| rx_byte | input | 8 | Head byte of the receive source |
| rx_pop | output | 1 | Consume the head receive byte at this edge |
| irq | output | 1 | Interrupt request to the host |

## Verification
The hardest point to reach is the receive delay that follows a data read while more bytes remain. The source must hold two bytes, the first read must leave the flag high so no rising edge occurs, and the pending bit must then appear exactly DELAY_CYCLES + 1 edges after the read. The bench models a small receive queue, pushes two bytes at once, and samples the interrupt one cycle before and exactly at that edge. It also holds a transmit interrupt and a receive interrupt pending together, to show the priority of the identification read and that this read clears only the transmit side.

// File: rtl/serial_csr_front_pkg.sv
package serial_csr_front_pkg;

   localparam int OFS_W  = 3;
   localparam int BYTE_W = 8;

   typedef enum logic [OFS_W-1:0] {
      OFS_DATA    = 3'd0,
      OFS_IEN     = 3'd1,
      OFS_IDENT   = 3'd2,
      OFS_LINE    = 3'd3,
      OFS_MODEM   = 3'd4,
      OFS_LSTAT   = 3'd5,
      OFS_MSTAT   = 3'd6,
      OFS_SCRATCH = 3'd7
   } reg_ofs_e;

   localparam int IEN_RX_BIT   = 0;
   localparam int IEN_TX_BIT   = 1;
   localparam int LINE_DIV_BIT = 7;

   localparam logic [BYTE_W-1:0] ID_RX      = 8'h04;
   localparam logic [BYTE_W-1:0] ID_TX      = 8'h02;
   localparam logic [BYTE_W-1:0] ID_NONE    = 8'h01;
   localparam logic [BYTE_W-1:0] LSTAT_IDLE = 8'h60;
   localparam logic [BYTE_W-1:0] MODEM_CMD  = 8'h1A;
   localparam logic [BYTE_W-1:0] MODEM_VAL  = 8'h9A;

   localparam int CH_RX = 0;
   localparam int CH_TX = 1;
   localparam int N_CH  = 2;

   typedef struct packed {
      logic rd_data;
      logic wr_data;
      logic rd_ident;
      logic wr_ien;
      logic wr_line;
      logic wr_modem;
   } access_s;

endpackage

// File: rtl/serial_csr_decode.sv
module serial_csr_decode
   import serial_csr_front_pkg::*;
(
   input  logic             sel,
   input  logic             wr,
   input  logic [OFS_W-1:0] ofs,
   input  logic             div_sel,
   output access_s          acc
);

   logic rd;
   logic wr_s;

   assign rd   = sel && !wr;
   assign wr_s = sel && wr;

   always_comb begin
      acc          = '0;
      acc.rd_data  = rd   && (ofs == OFS_DATA) && !div_sel;
      acc.wr_data  = wr_s && (ofs == OFS_DATA) && !div_sel;
      acc.wr_ien   = wr_s && (ofs == OFS_IEN)  && !div_sel;
      acc.rd_ident = rd   && (ofs == OFS_IDENT);
      acc.wr_line  = wr_s && (ofs == OFS_LINE);
      acc.wr_modem = wr_s && (ofs == OFS_MODEM);
   end

endmodule

// File: rtl/serial_csr_timer.sv
module serial_csr_timer #(
   parameter int DELAY_CYCLES = 450
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic cancel,
   output logic expire
);

   localparam int CW = $clog2(DELAY_CYCLES + 1);

   logic [CW-1:0] cnt_q;
   logic          run_q;

   assign expire = run_q && (cnt_q == CW'(1)) && !start && !cancel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (start) begin
         cnt_q <= CW'(DELAY_CYCLES);
         run_q <= 1'b1;
      end else if (cancel) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (run_q) begin
         if (cnt_q == CW'(1)) begin
            cnt_q <= '0;
            run_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - CW'(1);
         end
      end
   end

   // R9: a running timer always holds a count inside its interval
   assert_cnt_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q != '0) && (cnt_q <= CW'(DELAY_CYCLES)));

   // R9: a start always reloads the full interval
   assert_reload_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> run_q && (cnt_q == CW'(DELAY_CYCLES)));

endmodule

// File: rtl/serial_csr_pending.sv
module serial_csr_pending (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_en,
   input  logic tx_en,
   input  logic rx_arrive,
   input  logic rx_expire,
   input  logic tx_expire,
   input  logic rx_clr_read,
   input  logic tx_clr_access,
   input  logic rx_disable,
   input  logic tx_disable,
   output logic rx_pend,
   output logic tx_pend
);

   logic rx_d;
   logic tx_d;

   always_comb begin
      rx_d = rx_pend;
      if (rx_en && (rx_arrive || rx_expire)) rx_d = 1'b1;
      if (rx_clr_read)                      rx_d = 1'b0;
      if (rx_disable)                       rx_d = 1'b0;

      tx_d = tx_pend;
      if (tx_clr_access)                    tx_d = 1'b0;
      if (tx_en && tx_expire)               tx_d = 1'b1;
      if (tx_disable)                       tx_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_pend <= 1'b0;
         tx_pend <= 1'b0;
      end else begin
         rx_pend <= rx_d;
         tx_pend <= tx_d;
      end
   end

   // R9: transmit-pending rises only while the transmit enable is set
   assert_tx_rise_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_pend) |-> $past(tx_en));

   // R11: receive-pending rises only while the receive enable is set
   assert_rx_rise_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_pend) |-> $past(rx_en));

   // R6: an identification read with no expiry leaves transmit-pending clear
   assert_ident_clears_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_clr_access && !tx_expire) |=> !tx_pend);

   // R3: a data read leaves receive-pending clear
   assert_read_clears_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_clr_read |=> !rx_pend);

endmodule

// File: rtl/serial_csr_front.sv
module serial_csr_front
   import serial_csr_front_pkg::*;
#(
   parameter int DELAY_CYCLES = 450
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [2:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   output logic             tx_valid,
   output logic [7:0]       tx_byte,
   input  logic             rx_avail,
   input  logic [7:0]       rx_byte,
   output logic             rx_pop,
   output logic             irq
);

   if (DELAY_CYCLES < 1) begin : g_bad_delay
      $error("serial_csr_front: DELAY_CYCLES must be at least 1");
   end

   access_s          acc;
   logic [BYTE_W-1:0] ien_q;
   logic [BYTE_W-1:0] line_q;
   logic [BYTE_W-1:0] modem_q;
   logic             rx_avail_q;
   logic             recheck_q;
   logic             div_sel;
   logic             rx_pend;
   logic             tx_pend;
   logic [N_CH-1:0]  t_start;
   logic [N_CH-1:0]  t_cancel;
   logic [N_CH-1:0]  t_expire;
   logic             rx_arrive;
   logic [BYTE_W-1:0] ident;
   logic [BYTE_W-1:0] mux;

   assign div_sel = line_q[LINE_DIV_BIT];

   serial_csr_decode u_decode (
      .sel     (bus_sel),
      .wr      (bus_wr),
      .ofs     (bus_addr),
      .div_sel (div_sel),
      .acc     (acc)
   );

   // Register storage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien_q      <= '0;
         line_q     <= '0;
         modem_q    <= '0;
         rx_avail_q <= 1'b0;
         recheck_q  <= 1'b0;
      end else begin
         if (acc.wr_ien)  ien_q  <= bus_wdata;
         if (acc.wr_line) line_q <= bus_wdata;
         if (acc.wr_modem && (bus_wdata == MODEM_CMD)) modem_q <= MODEM_VAL;
         rx_avail_q <= rx_avail;
         recheck_q  <= acc.rd_data;
      end
   end

   assign rx_arrive = rx_avail && !rx_avail_q;

   // Timer control, index CH_RX and CH_TX
   always_comb begin
      t_start[CH_TX]  = (acc.wr_data && ien_q[IEN_TX_BIT]) ||
                        (acc.wr_ien && bus_wdata[IEN_TX_BIT]);
      t_cancel[CH_TX] = acc.wr_ien && !bus_wdata[IEN_TX_BIT];
      t_cancel[CH_RX] = acc.wr_ien && !(bus_wdata[IEN_RX_BIT] && rx_avail);
      t_start[CH_RX]  = (acc.wr_ien && bus_wdata[IEN_RX_BIT] && rx_avail) ||
                        (!acc.wr_ien && recheck_q && rx_avail && ien_q[IEN_RX_BIT]);
   end

   for (genvar g = 0; g < N_CH; g++) begin : g_timer
      serial_csr_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
         .clk    (clk),
         .rst_n  (rst_n),
         .start  (t_start[g]),
         .cancel (t_cancel[g]),
         .expire (t_expire[g])
      );
   end

   serial_csr_pending u_pending (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_en         (ien_q[IEN_RX_BIT]),
      .tx_en         (ien_q[IEN_TX_BIT]),
      .rx_arrive     (rx_arrive),
      .rx_expire     (t_expire[CH_RX]),
      .tx_expire     (t_expire[CH_TX]),
      .rx_clr_read   (acc.rd_data),
      .tx_clr_access (acc.wr_data || acc.rd_ident),
      .rx_disable    (acc.wr_ien && !bus_wdata[IEN_RX_BIT]),
      .tx_disable    (acc.wr_ien && !bus_wdata[IEN_TX_BIT]),
      .rx_pend       (rx_pend),
      .tx_pend       (tx_pend)
   );

   assign irq = rx_pend || tx_pend;

   // Read path
   always_comb begin
      if (rx_pend)      ident = ID_RX;
      else if (tx_pend) ident = ID_TX;
      else              ident = ID_NONE;
   end

   always_comb begin
      mux = '0;
      unique case (reg_ofs_e'(bus_addr))
         OFS_DATA:    mux = (!div_sel && rx_avail) ? rx_byte : '0;
         OFS_IEN:     mux = div_sel ? '0 : ien_q;
         OFS_IDENT:   mux = ident;
         OFS_LINE:    mux = line_q;
         OFS_MODEM:   mux = modem_q;
         OFS_LSTAT:   mux = LSTAT_IDLE | {{(BYTE_W-1){1'b0}}, rx_avail};
         OFS_MSTAT:   mux = '0;
         OFS_SCRATCH: mux = '0;
         default:     mux = '0;
      endcase
   end

   assign bus_rdata = (bus_sel && !bus_wr) ? mux : '0;
   assign rx_pop    = acc.rd_data && rx_avail;
   assign tx_valid  = acc.wr_data;
   assign tx_byte   = acc.wr_data ? bus_wdata : '0;

   // R3: a pop is only issued against available data
   assert_pop_needs_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |-> rx_avail);

   // R2: divisor select blocks the transmit strobe
   assert_div_blocks_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && (bus_addr == 3'd0) && line_q[LINE_DIV_BIT]) |-> !tx_valid);

   // R10: modem control only ever holds its reset value or the loop value
   assert_modem_values_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (modem_q == '0) || (modem_q == MODEM_VAL));

   // R4: a transmitted byte leaves transmit-pending clear on the next cycle
   assert_tx_write_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> !tx_pend);

   // R11: fresh data with the receive enable set raises the interrupt next cycle
   assert_arrive_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_arrive && ien_q[IEN_RX_BIT] && !acc.rd_data && !acc.wr_ien) |=> irq);

endmodule

// File: tb/serial_csr_front_bench.sv
module serial_csr_front_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DLY        = 450;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       tx_valid;
   logic [7:0] tx_byte;
   logic       rx_avail;
   logic [7:0] rx_byte;
   logic       rx_pop;
   logic       irq;

   logic [7:0] rxq [0:15];
   logic [4:0] wr_i = '0;
   logic [4:0] rd_i = '0;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic       seen_tx_valid;
   logic [7:0] seen_tx_byte;
   logic       seen_pop;
   logic [7:0] rv;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign rx_avail = (wr_i != rd_i);
   assign rx_byte  = rxq[rd_i[3:0]];

   always @(posedge clk) if (rx_pop) rd_i <= rd_i + 5'd1;

   serial_csr_front #(.DELAY_CYCLES(DLY)) u_serial_csr_front (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_valid(tx_valid), .tx_byte(tx_byte), .rx_avail(rx_avail),
      .rx_byte(rx_byte), .rx_pop(rx_pop), .irq(irq)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      #1;
      seen_tx_valid = tx_valid;
      seen_tx_byte  = tx_byte;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      seen_pop = rx_pop;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input logic [7:0] b);
      rxq[wr_i[3:0]] = b;
      wr_i = wr_i + 5'd1;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R12 watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // Reset state (R1, R12, R5, R7)
      chk("R12 irq after reset", {7'd0, irq}, 8'h00);
      rd_reg(3'd1, rv); chk("R1 ien reset", rv, 8'h00);
      rd_reg(3'd3, rv); chk("R1 line reset", rv, 8'h00);
      rd_reg(3'd4, rv); chk("R1 modem reset", rv, 8'h00);
      rd_reg(3'd2, rv); chk("R5 ident none", rv, 8'h01);
      rd_reg(3'd5, rv); chk("R7 lstat idle", rv, 8'h60);

      // R1 sweeps: line control and interrupt enable read back
      for (int v = 0; v < 256; v++) begin
         wr_reg(3'd3, 8'(v)); rd_reg(3'd3, rv); chk("R1 line readback", rv, 8'(v));
      end
      wr_reg(3'd3, 8'h03);
      for (int v = 0; v < 256; v++) begin
         wr_reg(3'd1, 8'(v)); rd_reg(3'd1, rv); chk("R1 ien readback", rv, 8'(v));
      end
      wr_reg(3'd1, 8'h00);
      chk("R8 irq after disable", {7'd0, irq}, 8'h00);
      rd_reg(3'd6, rv); chk("R1 mstat zero", rv, 8'h00);
      rd_reg(3'd7, rv); chk("R1 scratch zero", rv, 8'h00);

      // R8/R9: transmit delay lands exactly after DLY edges
      wr_reg(3'd1, 8'h02);
      idle(DLY-1); chk("R9 tx not early", {7'd0, irq}, 8'h00);
      idle(1);     chk("R9 tx on time", {7'd0, irq}, 8'h01);
      rd_reg(3'd2, rv); chk("R5 ident tx", rv, 8'h02);
      chk("R6 ident read clears tx", {7'd0, irq}, 8'h00);

      // R9 reload via data write, R4 strobe
      wr_reg(3'd1, 8'h02);
      idle(200);
      wr_reg(3'd0, 8'h5A);
      chk("R4 tx strobe", {7'd0, seen_tx_valid}, 8'h01);
      chk("R4 tx byte", seen_tx_byte, 8'h5A);
      idle(DLY-1); chk("R9 reload not early", {7'd0, irq}, 8'h00);
      idle(1);     chk("R9 reload on time", {7'd0, irq}, 8'h01);
      wr_reg(3'd0, 8'h33);
      chk("R4 write clears tx", {7'd0, irq}, 8'h00);
      idle(DLY);   chk("R4 write restarts delay", {7'd0, irq}, 8'h01);
      wr_reg(3'd1, 8'h00);
      chk("R8 disable clears tx", {7'd0, irq}, 8'h00);

      // R8 cancel of a running delay
      wr_reg(3'd1, 8'h02);
      idle(100);
      wr_reg(3'd1, 8'h00);
      idle(DLY+50); chk("R8 cancel holds", {7'd0, irq}, 8'h00);

      // R8 receive enable without data starts nothing
      wr_reg(3'd1, 8'h01);
      idle(DLY+50); chk("R8 rx no data no irq", {7'd0, irq}, 8'h00);

      // R11 arrival, R3 read, R11 delayed re-raise
      push(8'hA1); push(8'hB2);
      idle(1);     chk("R11 arrival raises irq", {7'd0, irq}, 8'h01);
      rd_reg(3'd2, rv); chk("R5 ident rx", rv, 8'h04);
      chk("R6 ident keeps rx", {7'd0, irq}, 8'h01);
      rd_reg(3'd5, rv); chk("R7 lstat ready", rv, 8'h61);
      rd_reg(3'd0, rv); chk("R3 read first byte", rv, 8'hA1);
      chk("R3 read clears rx", {7'd0, irq}, 8'h00);
      idle(DLY);   chk("R11 recheck not early", {7'd0, irq}, 8'h00);
      idle(1);     chk("R11 recheck on time", {7'd0, irq}, 8'h01);
      rd_reg(3'd0, rv); chk("R3 read second byte", rv, 8'hB2);
      idle(DLY+50); chk("R11 no data no restart", {7'd0, irq}, 8'h00);
      rd_reg(3'd0, rv); chk("R3 empty read zero", rv, 8'h00);
      chk("R3 empty read no pop", {7'd0, seen_pop}, 8'h00);
      rd_reg(3'd5, rv); chk("R7 lstat empty", rv, 8'h60);

      // R5/R6 priority with both pending
      wr_reg(3'd1, 8'h03);
      idle(DLY);   chk("R9 tx pending", {7'd0, irq}, 8'h01);
      push(8'hC3);
      idle(1);
      rd_reg(3'd2, rv); chk("R5 rx beats tx", rv, 8'h04);
      rd_reg(3'd0, rv); chk("R3 read priority byte", rv, 8'hC3);
      chk("R12 irq both clear", {7'd0, irq}, 8'h00);
      rd_reg(3'd2, rv); chk("R6 tx was cleared", rv, 8'h01);
      wr_reg(3'd1, 8'h00);

      // R2 divisor select
      push(8'hD4);
      idle(1);
      chk("R11 no irq when disabled", {7'd0, irq}, 8'h00);
      wr_reg(3'd3, 8'h80);
      rd_reg(3'd0, rv); chk("R2 div data reads zero", rv, 8'h00);
      chk("R2 div read no pop", {7'd0, seen_pop}, 8'h00);
      wr_reg(3'd1, 8'hFF);
      wr_reg(3'd0, 8'h77); chk("R2 div write no strobe", {7'd0, seen_tx_valid}, 8'h00);
      rd_reg(3'd1, rv); chk("R2 div ien reads zero", rv, 8'h00);
      rd_reg(3'd3, rv); chk("R1 line div readback", rv, 8'h80);
      wr_reg(3'd3, 8'h03);
      rd_reg(3'd1, rv); chk("R2 ien untouched", rv, 8'h00);
      rd_reg(3'd5, rv); chk("R2 byte still queued", rv, 8'h61);
      rd_reg(3'd0, rv); chk("R3 queued byte", rv, 8'hD4);

      // R10 modem control, R12 ignored writes
      wr_reg(3'd4, 8'h55); rd_reg(3'd4, rv); chk("R10 other value dropped", rv, 8'h00);
      wr_reg(3'd4, 8'h1A); rd_reg(3'd4, rv); chk("R10 loop value stored", rv, 8'h9A);
      wr_reg(3'd4, 8'h00); rd_reg(3'd4, rv); chk("R10 later value dropped", rv, 8'h9A);
      wr_reg(3'd7, 8'hFF); rd_reg(3'd7, rv); chk("R12 scratch write ignored", rv, 8'h00);
      wr_reg(3'd2, 8'hFF); rd_reg(3'd2, rv); chk("R12 fifo write ignored", rv, 8'h01);
      chk("R12 irq idle at end", {7'd0, irq}, 8'h00);

      done = 1'b1;
      finish_run();
   end

endmodule